// File: doc/BRIEF.md
# Power-tiered dual-path drive controller

This block sits in front of a two-branch, load-modulated power amplifier. Each cycle it may take one complex baseband sample (I/Q). It produces two drive streams from that sample. The main-branch stream is the sample itself, delayed to match the pipeline. The auxiliary-branch stream is the same sample scaled by a branch amplitude ratio and rotated by a branch phase offset. The block also drives a digital code for the auxiliary branch bias.

The instantaneous input power is estimated as I² + Q² in fixed point. That estimate is compared against three programmable squared-magnitude thresholds, which sorts the sample into one of four power regions. Each region has a fixed amplitude ratio, a fixed phase offset (stored as a pre-scaled cosine/sine pair) and a bias policy. In the second-lowest region the bias code is linearly interpolated on the power estimate. Both streams and the bias code leave together, two cycles after the input strobe, under one output valid signal.

Top module: `pa_split_ctrl`

## Requirements
- R1: During and right after synchronous reset, out_valid is 0, all four drive outputs are 0 and bias_code equals 60, the code of the lowest-power region.
- R2: out_valid rises exactly two clock edges after in_valid is sampled high, and is 0 two edges after in_valid is sampled low.
- R3: When out_valid is 1, main_i/main_q equal the in_i/in_q sampled two edges earlier.
- R4: With p = I² + Q², the region is 3 if p >= thr3, else 2 if p >= thr2, else 1 if p >= thr1, else 0, so a value exactly on a threshold belongs to the higher region (thresholds must satisfy thr1 <= thr2 <= thr3).
- R5: aux_i = sat(rnd(A·I − B·Q)) and aux_q = sat(rnd(B·I + A·Q)), where rnd(x) = (x + 512) >>> 10 (floor shift) and (A, B) is (−267, 1513) in regions 0 and 1 (ratio 1.5, 100°), (0, 1536) in region 2 (1.5, 90°) and (134, 1530) in region 3 (1.5, 85°).
- R6: Every auxiliary result saturates to the signed 12-bit range [−2048, 2047], so a full-scale input never wraps.
- R7: bias_code is 60 in region 0, 120 in region 2 and 108 in region 3 (code = (V + 5.0 V) / 10 mV).
- R8: In region 1, bias_code = 120 + ((−12·f) >>> 4) with f = min((p − thr1) >> 16, 15), so the code moves from 120 toward 108 as power rises.
- R9: bias_code and the drive outputs hold their values on any cycle in which out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 12 | Input in-phase sample, signed |
| in_q | input | 12 | Input quadrature sample, signed |
| thr1 | input | 25 | Lowest squared-magnitude threshold |
| thr2 | input | 25 | Middle squared-magnitude threshold |
| thr3 | input | 25 | Highest squared-magnitude threshold |
| out_valid | output | 1 | Qualifies all outputs |
| main_i | output | 12 | Main-branch in-phase drive |
| main_q | output | 12 | Main-branch quadrature drive |
| aux_i | output | 12 | Auxiliary-branch in-phase drive |
| aux_q | output | 12 | Auxiliary-branch quadrature drive |
| bias_code | output | 8 | Auxiliary-branch bias code |

## Verification
On every cycle the assertions check the two-stage valid pipeline, the alignment of the main stream with the input, the holding of the bias code between samples, and that the bias code agrees with the region implied by the main output's power (fixed codes at the extremes, a bounded code in the transition region). Only the bench's sweeps can show the exact rotated and rounded auxiliary values, the saturation of full-scale corners, the interpolated bias steps, and the placement of samples that fall exactly on a threshold.

// File: rtl/pa_split_ctrl.sv
module pa_split_ctrl #(
  parameter int W       = 12,
  parameter int CW      = 13,
  parameter int CF      = 10,
  parameter int BW      = 8,
  parameter int FRAC_W  = 4,
  parameter int FRAC_SH = 16,
  parameter int A_LO    = -267,
  parameter int B_LO    = 1513,
  parameter int A_MID   = 0,
  parameter int B_MID   = 1536,
  parameter int A_HI    = 134,
  parameter int B_HI    = 1530,
  parameter int BIAS_R0 = 60,
  parameter int BIAS_LO = 120,
  parameter int BIAS_HI = 108
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic signed [W-1:0]   in_i,
  input  logic signed [W-1:0]   in_q,
  input  logic [2*W:0]          thr1,
  input  logic [2*W:0]          thr2,
  input  logic [2*W:0]          thr3,
  output logic                  out_valid,
  output logic signed [W-1:0]   main_i,
  output logic signed [W-1:0]   main_q,
  output logic signed [W-1:0]   aux_i,
  output logic signed [W-1:0]   aux_q,
  output logic [BW-1:0]         bias_code
);
  localparam int PW    = 2 * W + 1;
  localparam int AW    = W + CW + 1;
  localparam int FMAX  = (1 << FRAC_W) - 1;
  localparam int BDIFF = BIAS_HI - BIAS_LO;
  localparam logic signed [AW-1:0] MAXV = AW'((1 << (W - 1)) - 1);
  localparam logic signed [AW-1:0] MINV = -MAXV - 1;
  localparam logic signed [AW-1:0] RHALF = AW'(1 << (CF - 1));

  logic signed [2*W-1:0] sq_i, sq_q;
  assign sq_i = in_i * in_i;
  assign sq_q = in_q * in_q;

  logic                 v1;
  logic signed [W-1:0]  i1, q1;
  logic [PW-1:0]        p1;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      i1 <= '0;
      q1 <= '0;
      p1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) begin
        i1 <= in_i;
        q1 <= in_q;
        p1 <= PW'($unsigned(sq_i)) + PW'($unsigned(sq_q));
      end
    end
  end

  logic [1:0] rgn;
  assign rgn = (p1 >= thr3) ? 2'd3 : (p1 >= thr2) ? 2'd2 : (p1 >= thr1) ? 2'd1 : 2'd0;

  logic signed [AW-1:0] ca, cb, ie, qe, acc_i, acc_q;
  always_comb begin
    case (rgn)
      2'd2:    begin ca = AW'(A_MID); cb = AW'(B_MID); end
      2'd3:    begin ca = AW'(A_HI);  cb = AW'(B_HI);  end
      default: begin ca = AW'(A_LO);  cb = AW'(B_LO);  end
    endcase
  end
  assign ie    = AW'(i1);
  assign qe    = AW'(q1);
  assign acc_i = ((ca * ie - cb * qe) + RHALF) >>> CF;
  assign acc_q = ((cb * ie + ca * qe) + RHALF) >>> CF;

  function automatic logic signed [W-1:0] clip(input logic signed [AW-1:0] v);
    if (v > MAXV) return MAXV[W-1:0];
    if (v < MINV) return MINV[W-1:0];
    return v[W-1:0];
  endfunction

  logic [PW-1:0]     dlt;
  logic [FRAC_W-1:0] frac;
  int                step;
  assign dlt  = (p1 - thr1) >> FRAC_SH;
  assign frac = (dlt > PW'(FMAX)) ? FRAC_W'(FMAX) : dlt[FRAC_W-1:0];
  assign step = (BDIFF * int'(frac)) >>> FRAC_W;

  logic [BW-1:0] bias_nx;
  always_comb begin
    case (rgn)
      2'd0:    bias_nx = BW'(BIAS_R0);
      2'd1:    bias_nx = BW'(BIAS_LO + step);
      2'd2:    bias_nx = BW'(BIAS_LO);
      default: bias_nx = BW'(BIAS_HI);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      main_i    <= '0;
      main_q    <= '0;
      aux_i     <= '0;
      aux_q     <= '0;
      bias_code <= BW'(BIAS_R0);
    end else begin
      out_valid <= v1;
      if (v1) begin
        main_i    <= i1;
        main_q    <= q1;
        aux_i     <= clip(acc_i);
        aux_q     <= clip(acc_q);
        bias_code <= bias_nx;
      end
    end
  end

  logic signed [2*W-1:0] mo_i, mo_q;
  logic [PW-1:0]         p_out;
  assign mo_i  = main_i * main_i;
  assign mo_q  = main_q * main_q;
  assign p_out = PW'($unsigned(mo_i)) + PW'($unsigned(mo_q));

  // R2
  valid_stage1_chk: assert property (@(posedge clk) disable iff (rst) in_valid |=> v1);
  // R2
  valid_stage2_chk: assert property (@(posedge clk) disable iff (rst) v1 |=> out_valid);
  // R3
  main_align_chk: assert property (@(posedge clk) disable iff (rst)
    v1 |=> (main_i == $past(i1) && main_q == $past(q1)));
  // R9
  bias_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(bias_code));
  // R7
  bias_top_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && p_out >= thr3) |-> bias_code == BW'(BIAS_HI));
  // R7
  bias_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && p_out < thr1) |-> bias_code == BW'(BIAS_R0));
  // R8
  bias_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && p_out >= thr1 && p_out < thr2) |->
    (bias_code <= BW'(BIAS_LO) && bias_code >= BW'(BIAS_HI)));
endmodule

// File: tb/sim_pa_split_ctrl.sv
module sim_pa_split_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [11:0] in_i = '0, in_q = '0;
  logic [24:0] thr1 = 25'd1000000, thr2 = 25'd2250000, thr3 = 25'd3240000;
  logic out_valid;
  logic signed [11:0] main_i, main_q, aux_i, aux_q;
  logic [7:0] bias_code;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pa_split_ctrl u0 (.clk, .rst, .in_valid, .in_i, .in_q, .thr1, .thr2, .thr3,
                    .out_valid, .main_i, .main_q, .aux_i, .aux_q, .bias_code);

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sat12(input longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return int'(v);
  endfunction

  function automatic int region(input int p);
    if (p >= int'(thr3)) return 3;
    if (p >= int'(thr2)) return 2;
    if (p >= int'(thr1)) return 1;
    return 0;
  endfunction

  task automatic apply(input int i, input int q, input string tag);
    int p, r, a, b, ei, eq, eb, fr;
    longint si, sq;
    @(negedge clk);
    in_i = 12'(i); in_q = 12'(q); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    p = i * i + q * q;
    r = region(p);
    case (r)
      2: begin a = 0; b = 1536; end
      3: begin a = 134; b = 1530; end
      default: begin a = -267; b = 1513; end
    endcase
    si = longint'(a) * i - longint'(b) * q;
    sq = longint'(b) * i + longint'(a) * q;
    ei = sat12((si + 512) >>> 10);
    eq = sat12((sq + 512) >>> 10);
    fr = (p - int'(thr1)) >>> 16;
    if (fr > 15) fr = 15;
    case (r)
      0: eb = 60;
      1: eb = 120 + ((-12 * fr) >>> 4);
      2: eb = 120;
      default: eb = 108;
    endcase
    chk({tag, " R2 valid"}, int'(out_valid), 1);
    chk({tag, " R3 main_i"}, int'(main_i), i);
    chk({tag, " R3 main_q"}, int'(main_q), q);
    chk({tag, " R5 R6 aux_i"}, int'(aux_i), ei);
    chk({tag, " R5 R6 aux_q"}, int'(aux_q), eq);
    chk({tag, (r == 1) ? " R8 bias" : " R4 R7 bias"}, int'(bias_code), eb);
    @(negedge clk);
    chk({tag, " R2 valid low"}, int'(out_valid), 0);
    chk({tag, " R9 bias hold"}, int'(bias_code), eb);
    chk({tag, " R9 aux hold"}, int'(aux_i), ei);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 bias", int'(bias_code), 60);
    chk("R1 main", int'(main_i), 0);
    chk("R1 aux", int'(aux_q), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after release", int'(out_valid), 0);
    chk("R1 bias after release", int'(bias_code), 60);
    // R4 threshold edges: q=0, i on and just below each threshold root
    apply(999, 0, "edge1-");
    apply(1000, 0, "edge1");
    apply(1499, 0, "edge2-");
    apply(1500, 0, "edge2");
    apply(1799, 0, "edge3-");
    apply(1800, 0, "edge3");
    // R6 full-scale corners
    apply(-2048, -2048, "fs1");
    apply(2047, 2047, "fs2");
    apply(-2048, 2047, "fs3");
    apply(2047, -2048, "fs4");
    // sweep across all regions
    for (int ii = -2048; ii < 2048; ii += 64)
      for (int qq = -2048; qq < 2048; qq += 64)
        apply(ii, qq, "sweep");
    // fine sweep across the interpolated region, R8
    for (int ii = 1000; ii < 1500; ii += 7)
      apply(ii, 0, "ramp");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule